// File: doc/BRIEF.md
# Four-Lane Masked Vector Adder

This block holds a bank of sixteen vector registers and performs the element-by-element sum `vd = va + vb` on request. Each register has up to 64 elements of 64 bits. The elements are spread over four pipelined lanes, and element `i` always lives in and flows through lane `i mod 4`. Each lane takes one new element per cycle, so a full 64-element operation issues in 16 cycles.

Two settings govern an operation: a programmable length and a 64-bit per-element enable mask. Only elements below the length whose enable bit is set are written. All other destination elements keep their previous values. Both settings are captured when an operation is accepted.

A host port loads and reads register contents while the unit is idle. A single-cycle `start` pulse names the destination and source registers. `busy` covers the operation, and a one-cycle `done` pulse marks the cycle after the last writeback.

Top module: `vec_add_lanes`

## Requirements
- R1: A host write with `host_we` high while idle stores `host_wdata` into element `host_elem` of register `host_reg`. `host_rdata` shows that element combinationally for the current `host_reg`/`host_elem`.
- R2: For every element index `i` below the captured length whose mask bit `i` is 1, the destination element becomes `(va[i] + vb[i]) mod 2^64`, with no overflow indication.
- R3: Destination elements at index equal to or above the captured length keep their previous values.
- R4: A destination element whose mask bit (bit `i` of the mask for element `i`) is 0 keeps its previous value.
- R5: After reset the length is 64 and the mask is all ones. A length write above 64 is stored as 64. Length and mask are sampled at the clock edge that accepts `start`.
- R6: After reset `busy` and `done` are low. For a nonzero length L with G = ceil(L/4), `busy` rises at the accepting edge and falls G+2 edges later. `done` is high for exactly the one cycle after that edge, and all writes are complete when `done` is seen.
- R7: With length 0, `done` is high in the cycle right after the accepting edge, `busy` stays low, and no register changes.
- R8: A `start` that arrives while `busy` is high is ignored.
- R9: The destination may equal either source or both, and the result is the same as with distinct registers.
- R10: Host writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, sampled at the rising edge |
| vd | input | 4 | Destination register index |
| va | input | 4 | First source register index |
| vb | input | 4 | Second source register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_len_we | input | 1 | Load the length setting |
| cfg_len | input | 7 | New length, saturated at 64 |
| cfg_mask_we | input | 1 | Load the element mask |
| cfg_mask | input | 64 | New mask, bit i enables element i |
| host_we | input | 1 | Host element write strobe |
| host_reg | input | 4 | Host register index |
| host_elem | input | 6 | Host element index |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Element selected by host_reg and host_elem |

## Verification
Take the edge that accepts `start` as edge 0. For a length of L, `done` is due G+2 edges later, with G = ceil(L/4). For a zero length it is due right after edge 0. The bench works out this count before the operation begins. It then compares `busy` and `done` at every falling edge from the accepting edge to one cycle past the pulse, and any early, late or repeated pulse counts as a miscompare. Register contents are read back through the combinational host port only after `done` has been seen. During that readback each element is compared with the value from the bench's own array model, which applies the length cut-off, the mask and aliasing. The host-write and start pokes made mid-operation are checked in the same way, by reading back the untouched registers they aimed at.

// File: rtl/vec_add_lanes.sv
module vec_add_lanes #(
  parameter int NREG   = 16,
  parameter int MAXLEN = 64,
  parameter int EW     = 64,
  parameter int NLANE  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(NREG)-1:0]     vd,
  input  logic [$clog2(NREG)-1:0]     va,
  input  logic [$clog2(NREG)-1:0]     vb,
  output logic                        busy,
  output logic                        done,
  input  logic                        cfg_len_we,
  input  logic [$clog2(MAXLEN+1)-1:0] cfg_len,
  input  logic                        cfg_mask_we,
  input  logic [MAXLEN-1:0]           cfg_mask,
  input  logic                        host_we,
  input  logic [$clog2(NREG)-1:0]     host_reg,
  input  logic [$clog2(MAXLEN)-1:0]   host_elem,
  input  logic [EW-1:0]               host_wdata,
  output logic [EW-1:0]               host_rdata
);
  localparam int RW    = $clog2(NREG);
  localparam int EIW   = $clog2(MAXLEN);
  localparam int LW    = $clog2(MAXLEN+1);
  localparam int LNW   = $clog2(NLANE);
  localparam int SW    = EIW - LNW;
  localparam int SLOTS = MAXLEN / NLANE;

  logic [LW-1:0]     vlen, run_len;
  logic [MAXLEN-1:0] vmask, run_mask;
  logic [RW-1:0]     vd_q, va_q, vb_q;
  logic              iss, s1_v, s1_last, s2_v, s2_last;
  logic [SW-1:0]     grp, s1_slot, s2_slot;
  logic [NLANE-1:0]  lane_we, s1_we, s2_we;
  logic [NLANE-1:0][EW-1:0] rd_a, rd_b, host_rd, s1_a, s1_b, s2_sum;

  wire           accept   = start & ~busy;
  wire [LW-1:0]  len_m1   = run_len - LW'(1);
  wire [SW-1:0]  last_grp = len_m1[EIW-1:LNW];
  wire           finish   = s2_v & s2_last;
  wire [SW-1:0]  h_slot   = host_elem[EIW-1:LNW];

  assign host_rdata = host_rd[host_elem[LNW-1:0]];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam logic [LNW-1:0] LID = LNW'(l);
    logic [EW-1:0] mem [NREG*SLOTS];
    wire  [EIW-1:0] eidx = {grp, LID};

    assign rd_a[l]    = mem[{va_q, grp}];
    assign rd_b[l]    = mem[{vb_q, grp}];
    assign host_rd[l] = mem[{host_reg, h_slot}];
    assign lane_we[l] = iss && (LW'(eidx) < run_len) && run_mask[eidx];

    always_ff @(posedge clk) begin
      if (s2_v && s2_we[l])
        mem[{vd_q, s2_slot}] <= s2_sum[l];
      else if (host_we && !busy && host_elem[LNW-1:0] == LID)
        mem[{host_reg, h_slot}] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    s1_a <= rd_a;
    s1_b <= rd_b;
    for (int l = 0; l < NLANE; l++) s2_sum[l] <= s1_a[l] + s1_b[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;  done <= 1'b0;  iss <= 1'b0;
      s1_v <= 1'b0;  s1_last <= 1'b0;  s2_v <= 1'b0;  s2_last <= 1'b0;
      s1_we <= '0;   s2_we <= '0;  s1_slot <= '0;  s2_slot <= '0;
      grp <= '0;     vd_q <= '0;  va_q <= '0;  vb_q <= '0;
      vlen <= LW'(MAXLEN);  vmask <= '1;
      run_len <= '0; run_mask <= '0;
    end else begin
      done <= 1'b0;
      if (cfg_len_we)  vlen  <= (cfg_len > LW'(MAXLEN)) ? LW'(MAXLEN) : cfg_len;
      if (cfg_mask_we) vmask <= cfg_mask;

      if (accept) begin
        vd_q <= vd;  va_q <= va;  vb_q <= vb;
        run_len  <= vlen;
        run_mask <= vmask;
        grp  <= '0;
        iss  <= (vlen != '0);
        busy <= (vlen != '0);
        done <= (vlen == '0);
      end else if (iss) begin
        grp <= grp + SW'(1);
        if (grp == last_grp) iss <= 1'b0;
      end

      s1_v    <= iss;
      s1_last <= iss && (grp == last_grp);
      s1_slot <= grp;
      s1_we   <= lane_we;
      s2_v    <= s1_v;
      s2_last <= s1_last;
      s2_slot <= s1_slot;
      s2_we   <= s1_we;

      if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_add_lanes_chk.sv
module vec_add_lanes_chk #(
  parameter int MAXLEN = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic [$clog2(MAXLEN+1)-1:0] vlen
);
  assert_len_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vlen <= ($clog2(MAXLEN+1))'(MAXLEN));

  assert_busy_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_done_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_zero_len_quick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen == '0) |=> (done && !busy));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !$rose(busy)) |=> (busy || done));
endmodule

bind vec_add_lanes vec_add_lanes_chk #(.MAXLEN(MAXLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .vlen(vlen)
);

// File: tb/vec_add_lanes_tb.sv
module vec_add_lanes_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, busy, done;
  logic [3:0]  vd = '0, va = '0, vb = '0;
  logic        cfg_len_we = 1'b0, cfg_mask_we = 1'b0, host_we = 1'b0;
  logic [6:0]  cfg_len = '0;
  logic [63:0] cfg_mask = '0, host_wdata = '0, host_rdata;
  logic [3:0]  host_reg = '0;
  logic [5:0]  host_elem = '0;

  logic [63:0] refm [16][64];
  int          mlen = 64;
  logic [63:0] mmask = '1;
  int          checks = 0, fails = 0;
  bit          ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_add_lanes u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vd(vd), .va(va), .vb(vb),
    .busy(busy), .done(done), .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask), .host_we(host_we),
    .host_reg(host_reg), .host_elem(host_elem), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic host_wr(input int r, input int e, input logic [63:0] d);
    host_we = 1; host_reg = 4'(r); host_elem = 6'(e); host_wdata = d;
    @(negedge clk);
    host_we = 0;
    refm[r][e] = d;
  endtask

  task automatic set_len(input int l);
    cfg_len_we = 1; cfg_len = 7'(l);
    @(negedge clk);
    cfg_len_we = 0;
    mlen = (l > 64) ? 64 : l;
  endtask

  task automatic set_mask(input logic [63:0] m);
    cfg_mask_we = 1; cfg_mask = m;
    @(negedge clk);
    cfg_mask_we = 0;
    mmask = m;
  endtask

  task automatic read_reg(input int r, input string tag_active);
    for (int e = 0; e < 64; e++) begin
      host_reg = 4'(r); host_elem = 6'(e);
      #1;
      chk(host_rdata === refm[r][e], tag_active, host_rdata, refm[r][e]);
    end
    @(negedge clk);
  endtask

  task automatic run_op(input int d, input int a, input int b, input bit poke);
    logic [63:0] tmp [64];
    int g, n;
    string tag;
    for (int e = 0; e < 64; e++) tmp[e] = refm[a][e] + refm[b][e];
    g = (mlen + 3) / 4;
    start = 1; vd = 4'(d); va = 4'(a); vb = 4'(b);
    @(negedge clk);
    start = 0;
    if (mlen == 0) begin
      chk(done === 1'b1, "R7 done", 64'(done), 64'd1);
      chk(busy === 1'b0, "R7 busy", 64'(busy), 64'd0);
      @(negedge clk);
      chk(done === 1'b0, "R7 single pulse", 64'(done), 64'd0);
    end else begin
      n = g + 2;
      for (int k = 0; k <= n; k++) begin
        chk(busy === (k < n), "R6 busy", 64'(busy), 64'(k < n));
        chk(done === (k == n), "R6 done", 64'(done), 64'(k == n));
        if (poke && k == 0) begin
          start = 1; vd = 4'd15; va = 4'd0; vb = 4'd1;
          host_we = 1; host_reg = 4'd14; host_elem = 6'd0; host_wdata = 64'hDEAD_BEEF_0BAD_F00D;
        end
        @(negedge clk);
        start = 0; host_we = 0;
      end
      chk(done === 1'b0, "R6 single pulse", 64'(done), 64'd0);
    end
    for (int e = 0; e < 64; e++)
      if (e < mlen && mmask[e]) refm[d][e] = tmp[e];
    tag = (d == a || d == b) ? "R9 alias" : "R2/R3/R4 readback";
    read_reg(d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R6 reset busy", 64'(busy), 64'd0);
    chk(done === 1'b0, "R6 reset done", 64'(done), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: load every register through the host port
    for (int r = 0; r < 16; r++)
      for (int e = 0; e < 64; e++)
        host_wr(r, e, {$urandom, $urandom});
    for (int e = 0; e < 64; e++) begin
      host_wr(10, e, 64'hFFFF_FFFF_FFFF_FFFF);
      host_wr(11, e, 64'(e + 1));
    end
    read_reg(3, "R1 host readback");

    // R5 defaults, R2 full length
    run_op(2, 0, 1, 0);
    // R2 wraparound
    run_op(12, 10, 11, 0);

    // R3/R4 short length with sparse mask, R8/R10 pokes while busy
    set_len(5);
    set_mask(64'h0000_0000_0000_0015);
    run_op(3, 4, 5, 1);

    // R7 zero length
    set_len(0);
    run_op(6, 0, 1, 0);

    // R5 saturation and R9 alias with destination = first source
    set_len(100);
    set_mask(64'hF0F0_0F0F_A5A5_3C3C);
    run_op(7, 7, 8, 0);

    // R9 all three the same
    set_len(63);
    set_mask('1);
    run_op(9, 9, 9, 0);

    // lengths off and on lane boundaries
    set_len(1);
    run_op(13, 2, 3, 0);
    set_len(13);
    set_mask(64'hFFFF_FFFF_FFFF_EFF7);
    run_op(4, 5, 9, 0);
    set_len(4);
    run_op(5, 13, 4, 1);

    // R5 sampling: settings changed right after start do not affect the op
    set_len(8);
    set_mask('1);
    begin
      logic [63:0] tmp [64];
      for (int e = 0; e < 64; e++) tmp[e] = refm[0][e] + refm[2][e];
      start = 1; vd = 4'd8; va = 4'd0; vb = 4'd2;
      @(negedge clk);
      start = 0;
      cfg_len_we = 1; cfg_len = 7'd64; cfg_mask_we = 1; cfg_mask = '0;
      @(negedge clk);
      cfg_len_we = 0; cfg_mask_we = 0;
      while (busy) @(negedge clk);
      for (int e = 0; e < 8; e++) refm[8][e] = tmp[e];
      mlen = 64; mmask = '0;
      read_reg(8, "R5 settings sampled at start");
    end

    // R1/R8/R10: whole file, including poke targets 14 and 15
    for (int r = 0; r < 16; r++) read_reg(r, "R1/R8/R10 final scan");

    finish_run();
  end
endmodule